// File: doc/BRIEF.md
# GPIO Port Pad Configuration Controller

This block manages one eight-pin general-purpose I/O port. Software writes a small bank of registers over a simple register bus: a data latch, a global-select mask and three drive-mode bit planes. From these the block derives the control signals for every pad: output level, high-side and low-side driver enables, pull-up and pull-down enables, a slew-limit request and a digital input enable.

Each pin takes its 3-bit drive-mode code from the same bit position in the three drive-mode registers. The code selects one of eight electrical behaviours: strong push-pull with or without slew limiting, either single-sided open drain, a resistive pull in either direction, or high impedance with the digital input kept or cut. A global-select bit per pin chooses whether the pad follows the CPU data bit or a bit from the global output bus. When a pin is globally selected, its input level is also returned to the global input bus.

Reading the data register returns the live pad levels as seen through the input enables, not the latch. Software that does a read-modify-write on the data register can therefore copy an input level into the output latch. The register map is split into two banks. Bank 0 holds data at offset 0, global select at offset 1 and drive-mode plane 2 at offset 3. Bank 1 holds drive-mode plane 0 at offset 0 and plane 1 at offset 1.

Top module: `gpio_pad_port`

## Requirements
- R1: After reset every pin's drive-mode code is 110 (high-impedance analog) and the data and global-select registers hold 0. All driver, pull and slew outputs and all input enables are then low, and a data read returns 0.
- R2: Pin n's code is {plane2[n], plane1[n], plane0[n]}, with plane 2 the most significant bit. Bank 0 maps data to offset 0, global select to offset 1 and plane 2 to offset 3. Bank 1 maps plane 0 to offset 0 and plane 1 to offset 1. Every configuration register reads back the value last written, and unmapped offsets read 0.
- R3: Code 001 (strong) and code 101 (slow strong) drive high-side for data 1 and low-side for data 0. The slew-limit output is high only under code 101.
- R4: Code 000 (pull-down) drives high-side for data 1 and enables the pull-down for data 0. Code 011 (pull-up) enables the pull-up for data 1 and drives low-side for data 0. No pin ever has both pulls enabled.
- R5: Code 100 enables only the high-side driver, and only for data 1. Code 111 enables only the low-side driver, and only for data 0.
- R6: Codes 010 and 110 enable no driver and no pull, and they hold the pad output bit at 0 whatever the data. Code 110 also clears the input enable, so such a pin reads as 0. All other codes set the input enable.
- R7: A global-select bit of 0 makes the CPU data bit the pin's drive source. A bit of 1 makes the global output bus bit the source.
- R8: The global input bus bit of a pin equals its pad input, gated by the input enable, when the pin is globally selected. Otherwise it is 0.
- R9: A read of the data register returns the pad input levels ANDed with the input enables, not the latched data.
- R10: A register write takes effect at the clock edge. A data read in the same cycle as a drive-mode write still reflects the old mode, and the new mode is visible from the next cycle.
- R11: The high-side and low-side driver enables of a pin are never both asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_wr_bank | input | 1 | Bank of the write |
| bus_wr_addr | input | 2 | Offset of the write within the bank |
| bus_wdata | input | NPINS | Write data |
| bus_rd_bank | input | 1 | Bank of the read |
| bus_rd_addr | input | 2 | Offset of the read within the bank |
| bus_rd_data | output | NPINS | Read data (combinational) |
| pad_in | input | NPINS | Pad input levels |
| glob_drv | input | NPINS | Global output bus bits |
| glob_rcv | output | NPINS | Global input bus bits |
| pad_out | output | NPINS | Pad output level |
| pad_oe_hi | output | NPINS | High-side driver enable |
| pad_oe_lo | output | NPINS | Low-side driver enable |
| pad_pu_en | output | NPINS | Pull-up resistor enable |
| pad_pd_en | output | NPINS | Pull-down resistor enable |
| pad_slow | output | NPINS | Slew-limit enable |
| pad_ien | output | NPINS | Digital input enable |

## Verification
A drive-mode write and a data-register read can fall in the same cycle, because the read and write ports are separate. The bench provokes this with a pin in high-impedance digital mode and its pad held high. In one cycle it writes plane 2 to turn the pin analog and reads the data register. The read must still return 1 before the edge and 0 after it. The other mixed case is a globally selected pin whose pad drives the global input bus while the same level is read through the data register. Both paths are judged against the pad input and the select mask.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] B0_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] B0_GSEL = 2'd1;
    localparam logic [ADDR_W-1:0] B0_DM2  = 2'd3;
    localparam logic [ADDR_W-1:0] B1_DM0  = 2'd0;
    localparam logic [ADDR_W-1:0] B1_DM1  = 2'd1;

    typedef enum logic [2:0] {
        DM_PULL_DN     = 3'b000,
        DM_STRONG      = 3'b001,
        DM_HIZ_DIG     = 3'b010,
        DM_PULL_UP     = 3'b011,
        DM_OPEN_HI     = 3'b100,
        DM_STRONG_SLOW = 3'b101,
        DM_HIZ_ANA     = 3'b110,
        DM_OPEN_LO     = 3'b111
    } drive_mode_e;

    typedef struct packed {
        logic out;
        logic drv_hi;
        logic drv_lo;
        logic pull_up;
        logic pull_dn;
        logic slew_lim;
        logic in_en;
    } pad_ctl_t;

    function automatic pad_ctl_t decode_drive(input drive_mode_e m, input logic d);
        pad_ctl_t c;
        c = '0;
        case (m)
            DM_PULL_DN: begin
                c.out = d; c.drv_hi = d; c.pull_dn = ~d; c.in_en = 1'b1;
            end
            DM_STRONG: begin
                c.out = d; c.drv_hi = d; c.drv_lo = ~d; c.in_en = 1'b1;
            end
            DM_HIZ_DIG: begin
                c.in_en = 1'b1;
            end
            DM_PULL_UP: begin
                c.out = d; c.pull_up = d; c.drv_lo = ~d; c.in_en = 1'b1;
            end
            DM_OPEN_HI: begin
                c.out = d; c.drv_hi = d; c.in_en = 1'b1;
            end
            DM_STRONG_SLOW: begin
                c.out = d; c.drv_hi = d; c.drv_lo = ~d; c.slew_lim = 1'b1; c.in_en = 1'b1;
            end
            DM_OPEN_LO: begin
                c.out = d; c.drv_lo = ~d; c.in_en = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              wr_bank,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NPINS-1:0]  wdata,
    output logic [NPINS-1:0]  data_q,
    output logic [NPINS-1:0]  gsel_q,
    output logic [NPINS-1:0]  dm0_q,
    output logic [NPINS-1:0]  dm1_q,
    output logic [NPINS-1:0]  dm2_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            gsel_q <= '0;
            dm0_q  <= '0;
            dm1_q  <= '1;
            dm2_q  <= '1;
        end else if (wr) begin
            if (!wr_bank) begin
                case (wr_addr)
                    B0_DATA: data_q <= wdata;
                    B0_GSEL: gsel_q <= wdata;
                    B0_DM2:  dm2_q  <= wdata;
                    default: ;
                endcase
            end else begin
                case (wr_addr)
                    B1_DM0:  dm0_q <= wdata;
                    B1_DM1:  dm1_q <= wdata;
                    default: ;
                endcase
            end
        end
    end

    AST_RESET_ANALOG: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dm2_q == '1 && dm1_q == '1 && dm0_q == '0 && data_q == '0 && gsel_q == '0)); // R1

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr && !wr_bank && wr_addr == B0_DM2) |=> (dm2_q == $past(wdata))); // R10

endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl
    import gpio_port_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     dm2,
    input  logic     dm1,
    input  logic     dm0,
    input  logic     cpu_bit,
    input  logic     glob_bit,
    input  logic     gsel,
    input  logic     pad_in,
    output pad_ctl_t ctl,
    output logic     live,
    output logic     glob_rcv
);

    drive_mode_e mode;
    logic        src;

    always_comb begin
        mode     = drive_mode_e'({dm2, dm1, dm0});
        src      = gsel ? glob_bit : cpu_bit;
        ctl      = decode_drive(mode, src);
        live     = pad_in & ctl.in_en;
        glob_rcv = gsel & live;
    end

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
        !(ctl.drv_hi && ctl.drv_lo)); // R11

    AST_PULL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ctl.pull_up && ctl.pull_dn)); // R4

    AST_ANALOG_QUIET: assert property (@(posedge clk) disable iff (rst)
        ({dm2, dm1, dm0} == 3'b110) |-> !(ctl.in_en || ctl.drv_hi || ctl.drv_lo || glob_rcv)); // R6

    AST_SLEW_ONLY_SLOW: assert property (@(posedge clk) disable iff (rst)
        ctl.slew_lim |-> ({dm2, dm1, dm0} == 3'b101)); // R3

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              rd_bank,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NPINS-1:0]  live,
    input  logic [NPINS-1:0]  gsel_q,
    input  logic [NPINS-1:0]  dm0_q,
    input  logic [NPINS-1:0]  dm1_q,
    input  logic [NPINS-1:0]  dm2_q,
    output logic [NPINS-1:0]  rd_data
);

    always_comb begin
        rd_data = '0;
        if (!rd_bank) begin
            case (rd_addr)
                B0_DATA: rd_data = live;
                B0_GSEL: rd_data = gsel_q;
                B0_DM2:  rd_data = dm2_q;
                default: rd_data = '0;
            endcase
        end else begin
            case (rd_addr)
                B1_DM0:  rd_data = dm0_q;
                B1_DM1:  rd_data = dm1_q;
                default: rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_pad_port.sv
module gpio_pad_port
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_wr_bank,
    input  logic [ADDR_W-1:0] bus_wr_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    input  logic              bus_rd_bank,
    input  logic [ADDR_W-1:0] bus_rd_addr,
    output logic [NPINS-1:0]  bus_rd_data,
    input  logic [NPINS-1:0]  pad_in,
    input  logic [NPINS-1:0]  glob_drv,
    output logic [NPINS-1:0]  glob_rcv,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe_hi,
    output logic [NPINS-1:0]  pad_oe_lo,
    output logic [NPINS-1:0]  pad_pu_en,
    output logic [NPINS-1:0]  pad_pd_en,
    output logic [NPINS-1:0]  pad_slow,
    output logic [NPINS-1:0]  pad_ien
);

    logic [NPINS-1:0] data_q, gsel_q, dm0_q, dm1_q, dm2_q;
    logic [NPINS-1:0] live;
    pad_ctl_t         ctl [NPINS];

    gpio_cfg_regs #(.NPINS(NPINS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_wr),
        .wr_bank (bus_wr_bank),
        .wr_addr (bus_wr_addr),
        .wdata   (bus_wdata),
        .data_q  (data_q),
        .gsel_q  (gsel_q),
        .dm0_q   (dm0_q),
        .dm1_q   (dm1_q),
        .dm2_q   (dm2_q)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        gpio_pin_ctl u_pin (
            .clk      (clk),
            .rst      (rst),
            .dm2      (dm2_q[g]),
            .dm1      (dm1_q[g]),
            .dm0      (dm0_q[g]),
            .cpu_bit  (data_q[g]),
            .glob_bit (glob_drv[g]),
            .gsel     (gsel_q[g]),
            .pad_in   (pad_in[g]),
            .ctl      (ctl[g]),
            .live     (live[g]),
            .glob_rcv (glob_rcv[g])
        );
        assign pad_out[g]   = ctl[g].out;
        assign pad_oe_hi[g] = ctl[g].drv_hi;
        assign pad_oe_lo[g] = ctl[g].drv_lo;
        assign pad_pu_en[g] = ctl[g].pull_up;
        assign pad_pd_en[g] = ctl[g].pull_dn;
        assign pad_slow[g]  = ctl[g].slew_lim;
        assign pad_ien[g]   = ctl[g].in_en;
    end

    gpio_read_mux #(.NPINS(NPINS)) u_rdmux (
        .rd_bank (bus_rd_bank),
        .rd_addr (bus_rd_addr),
        .live    (live),
        .gsel_q  (gsel_q),
        .dm0_q   (dm0_q),
        .dm1_q   (dm1_q),
        .dm2_q   (dm2_q),
        .rd_data (bus_rd_data)
    );

    AST_READ_LIVE: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd_bank && bus_rd_addr == B0_DATA) |-> ((bus_rd_data & ~pad_in) == '0)); // R9

    AST_GLOB_MASKED: assert property (@(posedge clk) disable iff (rst)
        ((glob_rcv & ~(pad_in & pad_ien)) == '0)); // R8

endmodule

// File: tb/gpio_pad_port_bench.sv
module gpio_pad_port_bench;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_wr = 1'b0;
    logic         bus_wr_bank = 1'b0;
    logic [1:0]   bus_wr_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic         bus_rd_bank = 1'b0;
    logic [1:0]   bus_rd_addr = '0;
    logic [N-1:0] bus_rd_data;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] glob_drv = '0;
    logic [N-1:0] glob_rcv, pad_out, pad_oe_hi, pad_oe_lo, pad_pu_en, pad_pd_en, pad_slow, pad_ien;

    always #4 clk = ~clk;

    gpio_pad_port #(.NPINS(N)) u_gpio_pad_port (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_wr_bank(bus_wr_bank), .bus_wr_addr(bus_wr_addr), .bus_wdata(bus_wdata),
        .bus_rd_bank(bus_rd_bank), .bus_rd_addr(bus_rd_addr), .bus_rd_data(bus_rd_data),
        .pad_in(pad_in), .glob_drv(glob_drv), .glob_rcv(glob_rcv),
        .pad_out(pad_out), .pad_oe_hi(pad_oe_hi), .pad_oe_lo(pad_oe_lo),
        .pad_pu_en(pad_pu_en), .pad_pd_en(pad_pd_en), .pad_slow(pad_slow), .pad_ien(pad_ien)
    );

    // kind 0: pad vector, 1: read data, 2: global input bus, 3: driver overlap
    typedef struct {
        int          kind;
        string       req;
        logic [55:0] exp;
    } sb_item_t;

    sb_item_t sb[$];
    sb_item_t it;
    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [55:0] got;

    always @(negedge clk) begin
        while (sb.size() > 0) begin
            it = sb.pop_front();
            case (it.kind)
                0: got = {pad_out, pad_oe_hi, pad_oe_lo, pad_pu_en, pad_pd_en, pad_slow, pad_ien};
                1: got = {48'd0, bus_rd_data};
                2: got = {48'd0, glob_rcv};
                default: got = {48'd0, pad_oe_hi & pad_oe_lo};
            endcase
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s kind%0d got %h expected %h", it.req, it.kind, got, it.exp);
            end
        end
    end

    // expected pin behaviour {out,hi,lo,pu,pd,slow,ien} from the requirement table
    function automatic logic [6:0] pin_exp(input logic [2:0] c, input logic d);
        case (c)
            3'b000: return {d, d, 1'b0, 1'b0, ~d, 1'b0, 1'b1};
            3'b001: return {d, d, ~d, 1'b0, 1'b0, 1'b0, 1'b1};
            3'b010: return 7'b0000001;
            3'b011: return {d, 1'b0, ~d, d, 1'b0, 1'b0, 1'b1};
            3'b100: return {d, d, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
            3'b101: return {d, d, ~d, 1'b0, 1'b0, 1'b1, 1'b1};
            3'b110: return 7'b0000000;
            default: return {d, 1'b0, ~d, 1'b0, 1'b0, 1'b0, 1'b1};
        endcase
    endfunction

    function automatic logic [55:0] exp_vec(input logic [7:0] m2, input logic [7:0] m1,
                                            input logic [7:0] m0, input logic [7:0] d);
        logic [7:0] o, h, l, u, p, s, e;
        for (int n = 0; n < 8; n++)
            {o[n], h[n], l[n], u[n], p[n], s[n], e[n]} = pin_exp({m2[n], m1[n], m0[n]}, d[n]);
        return {o, h, l, u, p, s, e};
    endfunction

    task automatic push(input int kind, input string req, input logic [55:0] exp);
        sb_item_t x;
        x.kind = kind; x.req = req; x.exp = exp;
        sb.push_back(x);
    endtask

    task automatic sync();
        @(negedge clk); #1;
    endtask

    task automatic wr_reg(input logic bank, input logic [1:0] addr, input logic [7:0] val);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_wr_bank = bank; bus_wr_addr = addr; bus_wdata = val;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic set_modes(input logic [7:0] m2, input logic [7:0] m1, input logic [7:0] m0);
        wr_reg(1'b0, 2'd3, m2);
        wr_reg(1'b1, 2'd1, m1);
        wr_reg(1'b1, 2'd0, m0);
    endtask

    task automatic rd_chk(input logic bank, input logic [1:0] addr, input logic [7:0] exp, input string req);
        bus_rd_bank = bank; bus_rd_addr = addr;
        push(1, req, {48'd0, exp});
        sync();
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        sync();

        // R1: reset state
        pad_in = 8'hFF;
        push(0, "R1", 56'd0);
        sync();
        rd_chk(1'b0, 2'd0, 8'h00, "R1");
        rd_chk(1'b0, 2'd1, 8'h00, "R1");
        rd_chk(1'b0, 2'd3, 8'hFF, "R1");
        rd_chk(1'b1, 2'd1, 8'hFF, "R1");
        rd_chk(1'b1, 2'd0, 8'h00, "R1");

        // R3 R4 R5 R6 R11: every code on all pins, mixed data
        wr_reg(1'b0, 2'd0, 8'hA5);
        for (int c = 0; c < 8; c++) begin
            logic [7:0] m2, m1, m0;
            string tag;
            m2 = {8{c[2]}}; m1 = {8{c[1]}}; m0 = {8{c[0]}};
            set_modes(m2, m1, m0);
            case (c)
                1, 5: tag = "R3";
                0, 3: tag = "R4";
                4, 7: tag = "R5";
                default: tag = "R6";
            endcase
            push(0, tag, exp_vec(m2, m1, m0, 8'hA5));
            push(3, "R11", 56'd0);
            sync();
        end

        // R2: per-pin code assembly and readback
        set_modes(8'h0F, 8'h33, 8'h55);
        wr_reg(1'b0, 2'd0, 8'h3C);
        push(0, "R2", exp_vec(8'h0F, 8'h33, 8'h55, 8'h3C));
        sync();
        rd_chk(1'b0, 2'd3, 8'h0F, "R2");
        rd_chk(1'b1, 2'd1, 8'h33, "R2");
        rd_chk(1'b1, 2'd0, 8'h55, "R2");
        rd_chk(1'b0, 2'd2, 8'h00, "R2");
        rd_chk(1'b1, 2'd3, 8'h00, "R2");

        // R7 R8: global select, strong mode on all pins
        set_modes(8'h00, 8'h00, 8'hFF);
        wr_reg(1'b0, 2'd0, 8'h00);
        glob_drv = 8'hAA;
        pad_in = 8'h3C;
        wr_reg(1'b0, 2'd1, 8'hF0);
        push(0, "R7", exp_vec(8'h00, 8'h00, 8'hFF, 8'hA0));
        push(2, "R8", {48'd0, 8'h30});
        sync();
        rd_chk(1'b0, 2'd1, 8'hF0, "R2");
        wr_reg(1'b0, 2'd1, 8'h00);
        push(0, "R7", exp_vec(8'h00, 8'h00, 8'hFF, 8'h00));
        push(2, "R8", 56'd0);
        sync();

        // R9: data read returns live pins, analog pins read 0
        set_modes(8'h00, 8'hFF, 8'h00);
        wr_reg(1'b0, 2'd0, 8'hFF);
        pad_in = 8'h0F;
        push(0, "R6", 56'h00_00_00_00_00_00_FF);
        sync();
        rd_chk(1'b0, 2'd0, 8'h0F, "R9");
        pad_in = 8'hFF;
        wr_reg(1'b0, 2'd3, 8'hF0);
        rd_chk(1'b0, 2'd0, 8'h0F, "R9");

        // R10: drive-mode write and data read in the same cycle
        wr_reg(1'b0, 2'd3, 8'h00);
        pad_in = 8'h01;
        bus_rd_bank = 1'b0; bus_rd_addr = 2'd0;
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_wr_bank = 1'b0; bus_wr_addr = 2'd3; bus_wdata = 8'h01;
        push(1, "R10", {48'd0, 8'h01});
        @(negedge clk); #1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        push(1, "R10", 56'd0);
        sync();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule